// File: doc/BRIEF.md
# I2C Interrupt Vector and Status Unit

This unit sits beside the byte engine of an I2C controller and turns its one-cycle event pulses into sticky status flags. An enable register selects which flags may raise the interrupt line. A vector register reports the single most urgent enabled event as a small code. Software reads the vector over and over to drain the pending work. Each read acknowledges the event it returns, until the code comes back as zero.

The receive-ready and transmit-ready events are acknowledged differently from the rest. They describe the state of the data path, not a one-off occurrence. Reading the vector does not clear them. They clear only when the data path reports that the receive byte was taken or the transmit byte was loaded. Two further status bits, receive-shift-full and bus-busy, follow live inputs. They never raise an interrupt.

Register access uses a two-bit address:
- 0: status
- 1: enable mask
- 2: vector
- 3: reads as zero

Read data is combinational from the current address. Writes and the acknowledge of a vector read take effect at the rising clock edge in which `reg_wr` or `reg_rd` is high.

Top module: `i2c_irq_vector_unit`

## Requirements
- R1: After a synchronous active-low reset, all event flags read 0, the enable mask reads 0x0027 (stop, access-ready, NACK and arbitration-lost enabled), the vector reads 0 and `irq_o` is low.
- R2: An event pulse on `evt_i[k]` sets status bit k in the following cycle, whether or not the event is enabled. The bit stays set until it is cleared. The bit order is: k=0 arbitration lost, 1 NACK, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop detected, 6 addressed as slave.
- R3: Writing the status register (address 0) clears every event flag whose write-data bit is 1 and leaves the others unchanged. If an event pulse and a clear hit the same flag in the same cycle, the flag ends up set.
- R4: The enable mask (address 1) is written from write-data bits 6:0 with the same bit order as R2. It reads back in bits 6:0, with bits 15:7 reading 0.
- R5: The vector (address 2) reads k+1 for the lowest k whose flag and enable bit are both set, and 0 when there is none. Arbitration lost (code 1) therefore wins over every other event.
- R6: A vector read (reg_rd at address 2) clears the flag of the event it reports, unless that event is receive ready (code 4) or transmit ready (code 5).
- R7: The receive-ready flag clears on `rx_taken_i` and the transmit-ready flag clears on `tx_loaded_i`, one cycle later. A vector read returning 4 or 5 leaves that flag set.
- R8: `irq_o` is high exactly when at least one flag is set together with its enable bit.
- R9: Status bit 11 mirrors `rx_full_i` and bit 12 mirrors `bus_busy_i` in the same cycle. Writes to these bits have no effect, and they never produce a vector or an interrupt. Bits 10:7 and 15:13 read 0.
- R10: A flag whose enable bit is 0 produces neither a vector nor an interrupt, but it stays pending. Once enabled, it is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 7 | One-cycle event pulses from the byte engine, bit order as in R2 |
| rx_taken_i | input | 1 | Receive byte consumed; clears receive ready |
| tx_loaded_i | input | 1 | Transmit byte loaded; clears transmit ready |
| rx_full_i | input | 1 | Live receive-shift-register-full level |
| bus_busy_i | input | 1 | Live bus-busy level |
| reg_addr | input | 2 | Register select: 0 status, 1 mask, 2 vector |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (acknowledges on the vector) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the addressed register |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a clash in one cycle. This covers a vector read or a status write that clears a flag while the engine sets the same flag again, and also a vector read landing on a receive or transmit code that must leave the flag intact. Directed sequences place an event pulse in the same cycle as its own clear. A long random phase then drives all event, clear, data-path and register strobes together. This makes coincident set, acknowledge and mask changes frequent, and a behavioural model judges every cycle.

// File: rtl/i2c_irq_pkg.sv
// Package: shared sizes, register addresses and event indices for the
// I2C interrupt vector unit. Assumes at most seven events so codes fit 3 bits.
package i2c_irq_pkg;
    localparam int EVT_N  = 7;
    localparam int DATA_W = 16;
    localparam int VEC_W  = $clog2(EVT_N + 1);

    // event positions; the order sets the vector priority
    localparam int EV_ARB   = 0;
    localparam int EV_NACK  = 1;
    localparam int EV_ARDY  = 2;
    localparam int EV_RXRDY = 3;
    localparam int EV_TXRDY = 4;
    localparam int EV_STOP  = 5;
    localparam int EV_SLAVE = 6;

    typedef enum logic [1:0] {
        ADDR_STATUS = 2'd0,
        ADDR_MASK   = 2'd1,
        ADDR_VECTOR = 2'd2,
        ADDR_NONE   = 2'd3
    } reg_addr_t;
endpackage

// File: rtl/i2c_irq_flag_bank.sv
// Flag bank: one sticky flag per event, set by a pulse and cleared by a
// per-bit clear request. When both arrive in the same cycle the set wins.
// Assumes clr_i is already the OR of every clear source.
module i2c_irq_flag_bank #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);
    for (genvar k = 0; k < N; k++) begin : g_flag
        // keep one flag: set dominates clear
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags_o[k] <= 1'b0;
            else if (set_i[k])
                flags_o[k] <= 1'b1;
            else if (clr_i[k])
                flags_o[k] <= 1'b0;
        end

        assert_set_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[k] |=> flags_o[k]);
        assert_clear_wins_alone_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[k] && !set_i[k]) |=> !flags_o[k]);
    end
endmodule

// File: rtl/i2c_irq_mask_reg.sv
// Enable mask register: loads on a write strobe, resets to a parameter value.
// Assumes the caller has already decoded the address.
module i2c_irq_mask_reg #(
    parameter int         N       = 7,
    parameter logic [N-1:0] RST_VAL = 7'h27
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] mask_o
);
    // hold or load the enable bits
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_o <= RST_VAL;
        else if (wr_i)
            mask_o <= wdata_i;
    end

    assert_mask_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (mask_o == $past(wdata_i)));
endmodule

// File: rtl/i2c_irq_prio_enc.sv
// Priority encoder: picks the lowest set request, returns its 1-based code
// and a one-hot grant. Code 0 and an empty grant mean no request.
module i2c_irq_prio_enc #(
    parameter int N     = 7,
    parameter int VEC_W = $clog2(N + 1)
) (
    input  logic [N-1:0]     req_i,
    output logic [VEC_W-1:0] code_o,
    output logic [N-1:0]     grant_o
);
    // scan from the top so the lowest index is assigned last
    always_comb begin
        code_o  = '0;
        grant_o = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req_i[k]) begin
                code_o     = VEC_W'(k + 1);
                grant_o    = '0;
                grant_o[k] = 1'b1;
            end
        end
    end

    // granted request is present and nothing below it is
    always_comb begin
        assert_grant_lowest_R5: assert ((grant_o == '0) ||
            (((grant_o & req_i) == grant_o) && ((req_i & (grant_o - 1'b1)) == '0)));
        assert_grant_onehot_R5: assert ($onehot0(grant_o));
    end
endmodule

// File: rtl/i2c_irq_vector_unit.sv
// I2C interrupt vector and status unit (top). Collects engine event pulses
// into sticky flags, gates them with an enable mask, encodes the most urgent
// enabled event as a vector code and raises an interrupt. A vector read
// acknowledges the reported event except receive/transmit ready, which the
// data path clears. Assumes single-cycle event pulses and a combinational
// read path sampled by the host in the same cycle as reg_rd.
module i2c_irq_vector_unit
    import i2c_irq_pkg::*;
#(
    parameter int         N_EVT    = EVT_N,
    parameter int         DW       = DATA_W,
    parameter int         RXF_BIT  = 11,
    parameter int         BUSY_BIT = 12,
    parameter logic [N_EVT-1:0] MASK_RST = 7'h27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] evt_i,
    input  logic             rx_taken_i,
    input  logic             tx_loaded_i,
    input  logic             rx_full_i,
    input  logic             bus_busy_i,
    input  logic [1:0]       reg_addr,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic             irq_o
);
    localparam int VW = $clog2(N_EVT + 1);
    localparam logic [N_EVT-1:0] KEEP_ON_ACK = N_EVT'((1 << EV_RXRDY) | (1 << EV_TXRDY));

    logic [N_EVT-1:0] flags, mask, pend_en, grant, clr;
    logic [N_EVT-1:0] data_clr, ack_clr, w1c_clr;
    logic [VW-1:0]    vec_code;
    logic             vec_rd, stat_wr, mask_wr;

    // decode register strobes
    always_comb begin
        vec_rd  = reg_rd && (reg_addr == ADDR_VECTOR);
        stat_wr = reg_wr && (reg_addr == ADDR_STATUS);
        mask_wr = reg_wr && (reg_addr == ADDR_MASK);
    end

    // gather every clear source per flag
    always_comb begin
        data_clr           = '0;
        data_clr[EV_RXRDY] = rx_taken_i;
        data_clr[EV_TXRDY] = tx_loaded_i;
        ack_clr            = vec_rd ? (grant & ~KEEP_ON_ACK) : '0;
        w1c_clr            = stat_wr ? reg_wdata[N_EVT-1:0] : '0;
        clr                = data_clr | ack_clr | w1c_clr;
    end

    i2c_irq_flag_bank #(.N(N_EVT)) i_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (evt_i),
        .clr_i   (clr),
        .flags_o (flags)
    );

    i2c_irq_mask_reg #(.N(N_EVT), .RST_VAL(MASK_RST)) i_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (mask_wr),
        .wdata_i (reg_wdata[N_EVT-1:0]),
        .mask_o  (mask)
    );

    assign pend_en = flags & mask;

    i2c_irq_prio_enc #(.N(N_EVT), .VEC_W(VW)) i_enc (
        .req_i   (pend_en),
        .code_o  (vec_code),
        .grant_o (grant)
    );

    assign irq_o = |pend_en;

    // read mux for the addressed register
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_STATUS: begin
                reg_rdata[N_EVT-1:0] = flags;
                reg_rdata[RXF_BIT]   = rx_full_i;
                reg_rdata[BUSY_BIT]  = bus_busy_i;
            end
            ADDR_MASK:   reg_rdata[N_EVT-1:0] = mask;
            ADDR_VECTOR: reg_rdata[VW-1:0]    = vec_code;
            default:     reg_rdata = '0;
        endcase
    end

    // interrupt line agrees with the encoder result
    assert_irq_vs_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (vec_code != '0));

    // an acknowledged ordinary event is gone next cycle unless re-raised
    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && ((grant & ~KEEP_ON_ACK) != '0) && ((grant & evt_i) == '0))
        |=> ((flags & $past(grant)) == '0));

    // reading a data-ready code keeps that flag when the data path is idle
    assert_ready_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && ((grant & KEEP_ON_ACK) != '0) && !stat_wr
         && ((grant & data_clr) == '0))
        |=> ((flags & $past(grant)) == $past(grant)));
endmodule

// File: tb/test_i2c_irq_vector_unit.sv
// Bench: a behavioural model (integers, bit operations) predicts read data
// and the interrupt line every cycle; directed phases then a random phase.
module test_i2c_irq_vector_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [6:0]  evt_i;
    logic        rx_taken_i, tx_loaded_i, rx_full_i, bus_busy_i;
    logic [1:0]  reg_addr;
    logic        reg_wr, reg_rd;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    int m_flags, m_mask;

    always #(CLK_PERIOD / 2) clk = ~clk;

    i2c_irq_vector_unit i_i2c_irq_vector_unit (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
        .rx_taken_i(rx_taken_i), .tx_loaded_i(tx_loaded_i),
        .rx_full_i(rx_full_i), .bus_busy_i(bus_busy_i),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    function automatic int model_code();
        int en = m_flags & m_mask;
        for (int k = 0; k < 7; k++)
            if (en[k]) return k + 1;
        return 0;
    endfunction

    function automatic int model_rdata();
        case (reg_addr)
            2'd0: return m_flags | (int'(rx_full_i) << 11) | (int'(bus_busy_i) << 12);
            2'd1: return m_mask;
            2'd2: return model_code();
            default: return 0;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // one cycle: compare comb outputs, then advance model at the edge
    task automatic step(input string tag);
        int code, clr;
        #1;
        check(tag, int'(reg_rdata), model_rdata());
        check({tag, " R8 irq"}, int'(irq_o), ((m_flags & m_mask) != 0) ? 1 : 0);
        code = model_code();
        clr = 0;
        if (reg_wr && reg_addr == 2'd0) clr |= int'(reg_wdata[6:0]);
        if (reg_rd && reg_addr == 2'd2 && code != 0 && code != 4 && code != 5)
            clr |= (1 << (code - 1));
        if (rx_taken_i)  clr |= (1 << 3);
        if (tx_loaded_i) clr |= (1 << 4);
        @(posedge clk);
        m_flags = (m_flags & ~clr) | int'(evt_i);
        if (reg_wr && reg_addr == 2'd1) m_mask = int'(reg_wdata[6:0]);
        @(negedge clk);
        evt_i = '0; rx_taken_i = 0; tx_loaded_i = 0;
        reg_wr = 0; reg_rd = 0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, input string tag);
        reg_addr = a; reg_rd = 1'b1; step(tag);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d, input string tag);
        reg_addr = a; reg_wr = 1'b1; reg_wdata = d; step(tag);
    endtask

    task automatic pulse(input logic [6:0] e, input string tag);
        evt_i = e; reg_addr = 2'd0; step(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 0; evt_i = '0; rx_taken_i = 0; tx_loaded_i = 0;
        rx_full_i = 0; bus_busy_i = 0; reg_addr = 0; reg_wr = 0; reg_rd = 0;
        reg_wdata = '0;
        m_flags = 0; m_mask = 'h27;
        @(negedge clk); @(negedge clk);
        rst_n = 1;

        // R1 reset values
        rd(2'd0, "R1 status"); rd(2'd1, "R1 mask"); rd(2'd2, "R1 vector");

        // R2 R5 R6 single arbitration loss, acknowledged by a vector read
        pulse(7'h01, "R2 set");
        rd(2'd0, "R2 status");
        rd(2'd2, "R6 ack code1"); rd(2'd2, "R6 drained");

        // R5 R6 several events drain in priority order
        pulse(7'h26, "R2 multi");
        rd(2'd2, "R5 code2"); rd(2'd2, "R5 code3"); rd(2'd2, "R5 code6");
        rd(2'd2, "R6 empty");

        // R5 arbitration loss outranks a pending stop
        pulse(7'h21, "R5 both");
        rd(2'd2, "R5 arb first"); rd(2'd2, "R5 stop next");

        // R7 receive ready stays through vector reads until data is taken
        wr(2'd1, 16'h003F, "R4 enable rx tx");
        pulse(7'h08, "R7 rx set");
        rd(2'd2, "R7 code4"); rd(2'd2, "R7 code4 again");
        rx_taken_i = 1; reg_addr = 2'd2; step("R7 rx taken");
        rd(2'd2, "R7 rx cleared");

        // R7 transmit ready cleared by load
        pulse(7'h10, "R7 tx set");
        rd(2'd2, "R7 code5");
        tx_loaded_i = 1; reg_addr = 2'd0; step("R7 tx load");
        rd(2'd0, "R7 tx cleared");

        // R10 disabled slave-address event stays pending
        pulse(7'h40, "R10 masked");
        rd(2'd2, "R10 no vector"); rd(2'd0, "R10 pending");
        wr(2'd1, 16'h007F, "R10 enable");
        rd(2'd2, "R10 code7 ack"); rd(2'd2, "R10 gone");

        // R3 write-one-to-clear and set-wins-on-clash
        pulse(7'h27, "R3 load");
        wr(2'd0, 16'h0005, "R3 w1c");
        rd(2'd0, "R3 after w1c");
        evt_i = 7'h02; reg_addr = 2'd0; reg_wr = 1; reg_wdata = 16'h0002; step("R3 clash");
        rd(2'd0, "R3 set wins");
        wr(2'd0, 16'hFFFF, "R3 clear all");

        // R9 live bits, write-immune, no interrupt
        rx_full_i = 1; bus_busy_i = 1;
        rd(2'd0, "R9 live");
        wr(2'd0, 16'h1800, "R9 write");
        rd(2'd0, "R9 unchanged"); rd(2'd2, "R9 no vector");
        rx_full_i = 0;
        rd(2'd0, "R9 follows");
        bus_busy_i = 0;

        // R4 upper bits read zero
        wr(2'd1, 16'hFFFF, "R4 write");
        rd(2'd1, "R4 readback");
        rd(2'd3, "R4 unmapped");

        // random phase: every strobe at once, model judges each cycle
        for (int i = 0; i < 3000; i++) begin
            evt_i       = 7'($urandom) & 7'($urandom);
            rx_taken_i  = ($urandom % 4) == 0;
            tx_loaded_i = ($urandom % 4) == 0;
            rx_full_i   = $urandom % 2;
            bus_busy_i  = $urandom % 2;
            reg_addr    = 2'($urandom);
            reg_rd      = $urandom % 2;
            reg_wr      = ($urandom % 5) == 0;
            reg_wdata   = 16'($urandom);
            step("R5 R6 R3 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule